// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block is the digital front end of a two-channel 12-bit converter that is loaded from an 8-bit processor bus. Each channel holds a staging register and a separate output register. The staging register is built from an 8-bit low part and a 4-bit high part. A write over the narrow bus fills one staging part at a time. The software can write the four parts in any order. A single shared load strobe then moves both channels' staged codes into their output registers together.

The output registers drive the converter codes. Each code is also presented as a 12-bit two's-complement value, which is the offset-binary code with its top bit inverted. The bus pins are asynchronous, so they pass through a synchroniser into the system clock domain. Each level-sensitive latch is modelled as a register that loads on every clock while its enable is active. A sticky flag reports a load strobe that rises during a bus write, or too soon after one. Such a load can capture a half-written code.

Top module: `dac_dual_front`

## Requirements
- R1: After reset, both output codes are 0x000, both signed views are 0x800 and the overlap flag is 0.
- R2: A bus write reaches a staging register only while `bus_cs_n` and `bus_wr_n` are both low. When either one is high, no staging part changes.
- R3: `bus_addr[1]` picks the channel (0 = A, 1 = B) and `bus_addr[0]` picks the part (0 = low 8 bits from `bus_data[7:0]`, 1 = high 4 bits from `bus_data[3:0]`). Bits `bus_data[7:4]` are ignored on a high-part write.
- R4: While `load_n` is high, writes to the staging registers leave both output codes unchanged.
- R5: While `load_n` is low, both output codes follow their staging registers together. The value present when `load_n` rises is then held.
- R6: The four staging parts may be written in any order, and each output code is formed as {high part, low part}.
- R7: Each signed output equals its output code with bit 11 inverted: code 0x800 gives 0x000, 0xFFF gives 0x7FF and 0x000 gives 0x800.
- R8: `overlap_err` sets when `load_n` rises while a bus write is active, or fewer than GUARD_CLKS clocks after a write ends. With the default of 4, a rise 3 clocks after the write ends sets the flag and a rise 4 clocks after does not.
- R9: `overlap_err` stays set until `err_clr` is pulsed high, and a clear pulse returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_addr | input | 2 | Bit 1 selects the channel, bit 0 selects the part |
| bus_data | input | 8 | Bus write data |
| load_n | input | 1 | Shared load strobe: low = transparent, rising edge = hold |
| err_clr | input | 1 | Clears the overlap flag |
| code_a | output | 12 | Channel A output code (offset binary) |
| code_b | output | 12 | Channel B output code (offset binary) |
| sgn_a | output | 12 | Channel A code in two's complement |
| sgn_b | output | 12 | Channel B code in two's complement |
| overlap_err | output | 1 | Sticky flag for a load strobe that came too close to a write |

## Verification
The two functions that can fall in the same cycle are a staging write and the transparent load path. When both are active, a write passes straight through to the output while the load strobe rises. The bench provokes this by holding `load_n` low, issuing a write, and releasing `load_n` 0, 3 and 4 clocks after the write strobe returns high. For each case it judges the captured codes against the staged values, and judges the overlap flag against the guard window: set for 0 and 3 clocks, clear for 4.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 12;
  localparam int HI_W   = CODE_W - DATA_W;
  localparam int ADDR_W = 2;
  localparam int NUM_CH = 2;
  localparam int CTRL_W = 3;
  localparam int SYNC_W = CTRL_W + ADDR_W + DATA_W;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              part_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer_en,
  output logic [CODE_W-1:0] code
);
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [CODE_W-1:0] out_q, out_d;
  logic              lo_en, hi_en;

  assign lo_en = wr_en & ~part_hi;
  assign hi_en = wr_en &  part_hi;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    out_d = out_q;
    if (lo_en)   lo_d  = wdata;
    if (hi_en)   hi_d  = wdata[HI_W-1:0];
    if (xfer_en) out_d = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      out_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      out_q <= out_d;
    end
  end

  assign code = out_q;

  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lo_q) && $stable(hi_q))); // R2
  AST_PART_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !part_hi) |=> $stable(hi_q)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(out_q)); // R4
endmodule

// File: rtl/dacif_overlap.sv
module dacif_overlap #(
  parameter int GUARD_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_act,
  input  logic load_lvl,
  input  logic err_clr,
  output logic err
);
  localparam int CNT_W = $clog2(GUARD_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GUARD_CLKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load_q;
  logic             err_q, err_d;
  logic             rise, early;

  assign rise  = load_lvl & ~load_q;
  assign early = wr_act | (cnt_q < CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_act)                cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    err_d = err_q;
    if (err_clr)        err_d = 1'b0;
    if (rise && early)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_MAX;
      load_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_lvl;
      err_q  <= err_d;
    end
  end

  assign err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err); // R9
  AST_ERR_ON_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(load_lvl) && wr_act) |=> err); // R8
endmodule

// File: rtl/dac_dual_front.sv
module dac_dual_front
  import dacif_pkg::*;
#(
  parameter int GUARD_CLKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              load_n,
  input  logic              err_clr,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] sgn_a,
  output logic [CODE_W-1:0] sgn_b,
  output logic              overlap_err
);
  localparam logic [SYNC_W-1:0] SYNC_RST = {{CTRL_W{1'b1}}, {(ADDR_W+DATA_W){1'b0}}};

  logic [SYNC_W-1:0] raw_bus, syn_bus;
  logic              cs_s, wr_s, load_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              wr_act;
  logic [CODE_W-1:0] codes [NUM_CH];

  assign raw_bus = {bus_cs_n, bus_wr_n, load_n, bus_addr, bus_data};

  dacif_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
  );

  assign {cs_s, wr_s, load_s, addr_s, data_s} = syn_bus;
  assign wr_act = ~cs_s & ~wr_s;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic sel;
    assign sel = wr_act & (addr_s[ADDR_W-1] == 1'(ch));
    dacif_channel u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(sel), .part_hi(addr_s[0]),
      .wdata(data_s), .xfer_en(~load_s), .code(codes[ch])
    );
  end

  dacif_overlap #(.GUARD_CLKS(GUARD_CLKS)) u_guard (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .load_lvl(load_s),
    .err_clr(err_clr), .err(overlap_err)
  );

  assign code_a = codes[0];
  assign code_b = codes[1];
  assign sgn_a  = {~code_a[CODE_W-1], code_a[CODE_W-2:0]};
  assign sgn_b  = {~code_b[CODE_W-1], code_b[CODE_W-2:0]};

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> ($stable(code_a) && $stable(code_b))); // R4
endmodule

// File: tb/test_dac_dual_front.sv
`timescale 1ns/1ps
module test_dac_dual_front;
  logic clk, rst_n, bus_cs_n, bus_wr_n, load_n, err_clr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_data;
  logic [11:0] code_a, code_b, sgn_a, sgn_b;
  logic        overlap_err;

  dac_dual_front i_dac_dual_front (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .load_n(load_n), .err_clr(err_clr),
    .code_a(code_a), .code_b(code_b), .sgn_a(sgn_a), .sgn_b(sgn_b),
    .overlap_err(overlap_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [11:0] a;
    logic [11:0] b;
    logic        err;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic cmp(string req, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.req, "code_a", code_a, e.a);
        cmp(e.req, "code_b", code_b, e.b);
        cmp("R7", "sgn_a", sgn_a, {~e.a[11], e.a[10:0]});
        cmp("R7", "sgn_b", sgn_b, {~e.b[11], e.b[10:0]});
        cmp(e.req, "overlap_err", {11'd0, overlap_err}, {11'd0, e.err});
      end
    end
  end

  task automatic expect_now(string req, logic [11:0] a, logic [11:0] b, logic err);
    exp_t e;
    repeat (6) @(negedge clk);
    e.a = a; e.b = b; e.err = err; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic bus_write(logic cs, logic wr, logic [1:0] addr, logic [7:0] data);
    @(negedge clk);
    bus_cs_n = cs; bus_wr_n = wr; bus_addr = addr; bus_data = data;
    repeat (3) @(negedge clk);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_pulse();
    idle(2);
    load_n = 1'b0;
    idle(4);
    load_n = 1'b1;
  endtask

  task automatic write_then_load(logic [1:0] addr, logic [7:0] data, int d);
    load_n = 1'b0;
    idle(4);
    bus_write(1'b0, 1'b0, addr, data);
    repeat (d) @(negedge clk);
    load_n = 1'b1;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_cs_n = 1'b1; bus_wr_n = 1'b1; load_n = 1'b1; err_clr = 1'b0;
    bus_addr = '0; bus_data = '0;
    idle(4);
    rst_n = 1'b1;
    expect_now("R1", 12'h000, 12'h000, 1'b0);

    // R3, R6: parts in mixed order, upper nibble of high-part data ignored; R4 hold
    bus_write(1'b0, 1'b0, 2'b00, 8'h34);
    bus_write(1'b0, 1'b0, 2'b01, 8'hF2);
    bus_write(1'b0, 1'b0, 2'b11, 8'h0A);
    bus_write(1'b0, 1'b0, 2'b10, 8'hCD);
    expect_now("R4", 12'h000, 12'h000, 1'b0);
    load_pulse();
    expect_now("R3", 12'h234, 12'hACD, 1'b0);

    // R2: only one of the two strobes low
    bus_write(1'b1, 1'b0, 2'b00, 8'hFF);
    bus_write(1'b0, 1'b1, 2'b11, 8'h0F);
    load_pulse();
    expect_now("R2", 12'h234, 12'hACD, 1'b0);

    // R5: transparent while load low, held after rise
    load_n = 1'b0;
    bus_write(1'b0, 1'b0, 2'b00, 8'hFF);
    bus_write(1'b0, 1'b0, 2'b01, 8'h0F);
    expect_now("R5", 12'hFFF, 12'hACD, 1'b0);
    idle(8);
    load_n = 1'b1;
    bus_write(1'b0, 1'b0, 2'b00, 8'h00);
    expect_now("R5", 12'hFFF, 12'hACD, 1'b0);

    // R8: load rises as the write ends
    bus_write(1'b0, 1'b0, 2'b10, 8'h00);
    bus_write(1'b0, 1'b0, 2'b11, 8'h08);
    write_then_load(2'b00, 8'h00, 0);
    expect_now("R8", 12'hF00, 12'h800, 1'b1);
    idle(10);
    expect_now("R9", 12'hF00, 12'h800, 1'b1);
    clear_err();
    expect_now("R9", 12'hF00, 12'h800, 1'b0);

    // R8 boundary: 3 clocks sets, 4 clocks does not
    write_then_load(2'b10, 8'h11, 3);
    expect_now("R8", 12'hF00, 12'h811, 1'b1);
    clear_err();
    write_then_load(2'b10, 8'h22, 4);
    expect_now("R8", 12'hF00, 12'h822, 1'b0);

    wait (q.size() == 0);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule